// File: doc/BRIEF.md
# Down-Spread Modulation Profile Controller

This controller sits in the digital half of a spread-spectrum clock generator and runs on the input reference clock. It outputs a signed frequency-offset command, in hundredths of a percent, for an external synthesizer. The command traces a triangle over a fixed modulation period. It starts at zero, falls to minus the selected depth at mid-period, and climbs back to zero. The offset is never positive, so the synthesized clock only ever runs at or below nominal.

The depth depends on two codes. A three-level spread setting is presented as a 2-bit code, and a 2-bit code gives the input frequency band. Both codes are sampled only when a period begins, so the profile never jumps partway through a period. A one-cycle marker flags the first cycle of every period.

An active-low power-down clears the phase and the offset and drops both output clock enables. The enable for the unmodulated reference path is high whenever the block is not powered down, and modulation never affects it.

Top module: `sscg_profile_ctrl`

## Requirements
- R1: `offset_cw` is always between minus the current depth and 0, inclusive, and is never positive.
- R2: While running, one modulation period lasts 512 clocks. `period_mark` is high for exactly one clock at phase 0 of each period, and `offset_cw` is 0 in that clock.
- R3: The spread code is decoded as follows: 2'b00 selects the low depth, 2'b10 the high depth, and 2'b01 the middle depth. The unused code 2'b11 also selects the middle depth.
- R4: Band codes map to depths (high/low/middle, in 0.01 % units) as follows: 2'b00 (16–20 MHz) 300/220/70; 2'b01 (20–24 MHz) 270/190/60; 2'b10 (24–28 MHz) 250/180/60; 2'b11 (28–32 MHz) 230/170/50.
- R5: At phase p of the period, `offset_cw` equals −floor(depth·t/256), where t = p for p ≤ 256 and t = 512 − p otherwise. At phase 256 the offset equals −depth.
- R6: A change on `spread_code` or `band_code` takes effect only when the next period starts. Until then the running period keeps its depth.
- R7: In the clock after `pd_n` is sampled low, `offset_cw` is 0 and `period_mark`, `ref_clk_en` and `mod_clk_en` are low. They stay that way while `pd_n` stays low, whatever the other inputs do.
- R8: In the first clock after `pd_n` is sampled high again, the block is at phase 0 with `period_mark` high, and counting continues from there.
- R9: `ref_clk_en` is high in every clock after `pd_n` is sampled high, whatever the spread and band settings and whatever the phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| spread_code | input | 2 | Decoded three-level spread setting |
| band_code | input | 2 | Input frequency band |
| offset_cw | output | 12 | Signed offset command, 0.01 % units |
| period_mark | output | 1 | One-clock marker at phase 0 |
| ref_clk_en | output | 1 | Enable for the unmodulated output path |
| mod_clk_en | output | 1 | Enable for the modulated output path |

## Verification
All outputs are registered. A sample taken after edge n therefore shows the phase reached at edge n. The first clock after `pd_n` is released is phase 0, and phase k is visible exactly k clocks later. The power-down response likewise appears one clock after `pd_n` is sampled low. The bench drives inputs and samples outputs on the falling edge. It tracks the phase with its own counter from the release edge and compares every cycle against a profile it computes from the requirement formula. To check that a setting change is deferred, the bench changes a code mid-period and expects the old depth until the next phase-0 clock.

// File: rtl/sscg_pkg.sv
package sscg_pkg;
  localparam int DEP_W = 9;

  typedef enum logic [1:0] {
    SPR_LOW  = 2'b00,
    SPR_MID  = 2'b01,
    SPR_HIGH = 2'b10,
    SPR_RSV  = 2'b11
  } spread_e;

  // depth in 0.01 % units for a band and a spread setting
  function automatic logic [DEP_W-1:0] depth_lookup(input logic [1:0] band,
                                                     input logic [1:0] sel);
    logic [DEP_W-1:0] hi, lo, mid;
    case (band)
      2'b00:   begin hi = 9'd300; lo = 9'd220; mid = 9'd70; end
      2'b01:   begin hi = 9'd270; lo = 9'd190; mid = 9'd60; end
      2'b10:   begin hi = 9'd250; lo = 9'd180; mid = 9'd60; end
      default: begin hi = 9'd230; lo = 9'd170; mid = 9'd50; end
    endcase
    case (spread_e'(sel))
      SPR_HIGH: return hi;
      SPR_LOW:  return lo;
      default:  return mid;
    endcase
  endfunction

  // triangle magnitude: distance from phase 0 folded at mid-period
  function automatic logic [15:0] fold_phase(input logic [15:0] ph, input int ph_w);
    logic [15:0] mask;
    mask = 16'((32'd1 << ph_w) - 1);
    if (ph[ph_w-1]) return (~ph + 16'd1) & mask;
    return ph & mask;
  endfunction
endpackage

// File: rtl/sscg_phase_counter.sv
module sscg_phase_counter #(
  parameter int PERIOD = 512,
  localparam int PH_W = $clog2(PERIOD)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            pd_n,
  output logic [PH_W-1:0] phase_nxt,
  output logic            start_nxt
);
  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD - 1);

  logic [PH_W-1:0] ph_q;
  logic            run_q;

  always_comb begin
    if (!run_q || ph_q == LAST) phase_nxt = '0;
    else                        phase_nxt = ph_q + 1'b1;
  end

  assign start_nxt = pd_n && (phase_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= '0;
      run_q <= 1'b0;
    end else if (!pd_n) begin
      ph_q  <= '0;
      run_q <= 1'b0;
    end else begin
      ph_q  <= phase_nxt;
      run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/sscg_depth_select.sv
module sscg_depth_select
  import sscg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [1:0]       band_code,
  input  logic [1:0]       spread_code,
  output logic [DEP_W-1:0] depth_eff
);
  logic [DEP_W-1:0] depth_q;
  logic [DEP_W-1:0] depth_new;

  assign depth_new = depth_lookup(band_code, spread_code);
  assign depth_eff = load ? depth_new : depth_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    depth_q <= '0;
    else if (load) depth_q <= depth_new;
  end
endmodule

// File: rtl/sscg_ramp_shaper.sv
module sscg_ramp_shaper
  import sscg_pkg::*;
#(
  parameter int PH_W  = 9,
  parameter int OFS_W = 12,
  localparam int PROD_W = PH_W + DEP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pd_n,
  input  logic [PH_W-1:0]         phase,
  input  logic                    start,
  input  logic [DEP_W-1:0]        depth,
  output logic signed [OFS_W-1:0] offset_q,
  output logic                    mark_q,
  output logic                    en_q
);
  logic [PH_W-1:0]   mag;
  logic [PROD_W-1:0] prod;
  logic [DEP_W-1:0]  quot;
  logic signed [OFS_W-1:0] ofs_nxt;

  assign mag     = PH_W'(fold_phase(16'(phase), PH_W));
  assign prod    = PROD_W'(depth) * PROD_W'(mag);
  assign quot    = DEP_W'(prod >> (PH_W - 1));
  assign ofs_nxt = OFS_W'(0) - OFS_W'(quot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset_q <= '0;
      mark_q   <= 1'b0;
      en_q     <= 1'b0;
    end else if (!pd_n) begin
      offset_q <= '0;
      mark_q   <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      offset_q <= ofs_nxt;
      mark_q   <= start;
      en_q     <= 1'b1;
    end
  end
endmodule

// File: rtl/sscg_profile_ctrl.sv
module sscg_profile_ctrl
  import sscg_pkg::*;
#(
  parameter int PERIOD = 512,
  parameter int OFS_W  = 12,
  localparam int PH_W  = $clog2(PERIOD)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    pd_n,
  input  logic [1:0]              spread_code,
  input  logic [1:0]              band_code,
  output logic signed [OFS_W-1:0] offset_cw,
  output logic                    period_mark,
  output logic                    ref_clk_en,
  output logic                    mod_clk_en
);
  logic [PH_W-1:0]  phase_nxt;
  logic             period_start;
  logic [DEP_W-1:0] depth_eff;
  logic             en_q;

  sscg_phase_counter #(.PERIOD(PERIOD)) u_phase (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n),
    .phase_nxt(phase_nxt), .start_nxt(period_start)
  );

  sscg_depth_select u_depth (
    .clk(clk), .rst_n(rst_n), .load(period_start),
    .band_code(band_code), .spread_code(spread_code),
    .depth_eff(depth_eff)
  );

  sscg_ramp_shaper #(.PH_W(PH_W), .OFS_W(OFS_W)) u_shape (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n),
    .phase(phase_nxt), .start(period_start), .depth(depth_eff),
    .offset_q(offset_cw), .mark_q(period_mark), .en_q(en_q)
  );

  assign ref_clk_en = en_q;
  assign mod_clk_en = en_q;
endmodule

// File: rtl/sscg_profile_ctrl_checker.sv
module sscg_profile_ctrl_checker #(
  parameter int PERIOD = 512,
  parameter int OFS_W  = 12,
  localparam int GAP_W = $clog2(PERIOD) + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    pd_n,
  input logic signed [OFS_W-1:0] offset_cw,
  input logic                    period_mark,
  input logic                    ref_clk_en,
  input logic                    mod_clk_en
);
  logic [GAP_W-1:0]        gap;
  logic                    seen;
  logic                    prev_ok;
  logic signed [OFS_W-1:0] prev_ofs;
  logic signed [OFS_W:0]   step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= '0; seen <= 1'b0; prev_ok <= 1'b0; prev_ofs <= '0;
    end else begin
      prev_ok  <= mod_clk_en;
      prev_ofs <= offset_cw;
      if (!mod_clk_en)      begin seen <= 1'b0; gap <= '0; end
      else if (period_mark) begin seen <= 1'b1; gap <= '0; end
      else                  gap <= gap + 1'b1;
    end
  end

  assign step = (OFS_W+1)'(offset_cw) - (OFS_W+1)'(prev_ofs);

  a_r1_never_above_nominal: assert property (@(posedge clk) disable iff (!rst_n)
    offset_cw <= 0 && offset_cw >= -300);
  a_r2_mark_period: assert property (@(posedge clk) disable iff (!rst_n)
    (period_mark && seen) |-> gap == GAP_W'(PERIOD - 1));
  a_r2_mark_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    period_mark |-> offset_cw == 0);
  a_r5_small_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_clk_en && prev_ok) |-> (step <= 2 && step >= -2));
  a_r7_powerdown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> (offset_cw == 0 && !period_mark && !ref_clk_en && !mod_clk_en));
  a_r8_restart_phase0: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_n && !mod_clk_en) |=> period_mark);
  a_r9_ref_running: assert property (@(posedge clk) disable iff (!rst_n)
    pd_n |=> ref_clk_en);
endmodule

bind sscg_profile_ctrl sscg_profile_ctrl_checker #(.PERIOD(PERIOD), .OFS_W(OFS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .offset_cw(offset_cw),
  .period_mark(period_mark), .ref_clk_en(ref_clk_en), .mod_clk_en(mod_clk_en)
);

// File: tb/sscg_profile_ctrl_bench.sv
module sscg_profile_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pd_n = 1'b1;
  logic [1:0] spread_code = 2'b01;
  logic [1:0] band_code = 2'b00;
  logic signed [11:0] offset_cw;
  logic period_mark, ref_clk_en, mod_clk_en;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sscg_profile_ctrl u_sscg_profile_ctrl (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .spread_code(spread_code),
    .band_code(band_code), .offset_cw(offset_cw), .period_mark(period_mark),
    .ref_clk_en(ref_clk_en), .mod_clk_en(mod_clk_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // R3/R4 encodings restated: sel 0 low, 1 mid, 2 high, 3 mid
  function automatic int want_depth(input int sel, input int band);
    int hi[4]  = '{300, 270, 250, 230};
    int lo[4]  = '{220, 190, 180, 170};
    int md[4]  = '{70, 60, 60, 50};
    if (sel == 2) return hi[band];
    if (sel == 0) return lo[band];
    return md[band];
  endfunction

  // R5 profile: distance-to-peak form
  function automatic int want_ofs(input int d, input int p);
    int t = 256 - ((p > 256) ? p - 256 : 256 - p);
    return -((d * t) / 256);
  endfunction

  // pulse power-down, leave the bench at phase 0 (first clock after release)
  task automatic restart(input int sel, input int band);
    @(negedge clk); pd_n = 1'b0; spread_code = 2'(sel); band_code = 2'(band);
    @(negedge clk); pd_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_period(input int d, input string req);
    for (int p = 0; p < 512; p++) begin
      chk(offset_cw == want_ofs(d, p), req, offset_cw, want_ofs(d, p));
      chk(period_mark == (p == 0), "R2", period_mark, p == 0);
      chk(ref_clk_en && mod_clk_en, "R9", ref_clk_en, 1);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(offset_cw == 0 && !period_mark && !ref_clk_en && !mod_clk_en,
        "R7 reset state", offset_cw, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_table;
    for (int s = 0; s < 4; s++)
      for (int b = 0; b < 4; b++) begin
        restart(s, b);
        repeat (256) @(negedge clk);
        chk(offset_cw == -want_depth(s, b), "R4 R3 peak", offset_cw, -want_depth(s, b));
      end
  endtask

  task automatic t_profiles;
    restart(2, 0); check_period(300, "R5 high b0");
    check_period(300, "R2 R5 second period");
    restart(3, 3); check_period(50, "R3 R5 code11");
    restart(0, 1); check_period(190, "R1 R5 low b1");
  endtask

  task automatic t_deferred;
    restart(2, 0);
    for (int p = 0; p < 512; p++) begin
      chk(offset_cw == want_ofs(300, p), "R6 old depth", offset_cw, want_ofs(300, p));
      if (p == 100) begin spread_code = 2'b01; band_code = 2'b11; end
      @(negedge clk);
    end
    check_period(50, "R6 new depth");
  endtask

  task automatic t_powerdown;
    restart(0, 3);
    repeat (300) @(negedge clk);
    pd_n = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(offset_cw == 0 && !period_mark && !ref_clk_en && !mod_clk_en,
          "R7 held", offset_cw, 0);
      spread_code = 2'(i); band_code = 2'(i + 1);
    end
    spread_code = 2'b00; band_code = 2'b11; pd_n = 1'b1;
    @(negedge clk);
    chk(period_mark && offset_cw == 0, "R8 restart", period_mark, 1);
    repeat (256) @(negedge clk);
    chk(offset_cw == -170, "R8 phase count", offset_cw, -170);
  endtask

  initial begin
    t_reset;
    t_table;
    t_profiles;
    t_deferred;
    t_powerdown;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_500_000;
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule